// File: doc/BRIEF.md
# Preset-Reload Truncated Counter

This block is a synchronous binary up-counter that runs through a shortened loop of states instead of its full binary range. Its own terminal-count carry is fed back as a load request. On the edge after the count reaches all ones, a fixed preset value is loaded in place of the wrap to zero. The loop therefore covers the states from the preset up to all ones, so the modulus is 2^WIDTH minus the preset, and no decoder for the end state is needed.

The count is built from 4-bit stages chained through their carries. The default is a 12-bit, three-stage counter with preset 0x800, which gives a modulus of 2048. A single 4-bit stage with preset 0x9 gives a modulus of 7 (states 9 through 15).

An external start request forces the preset at any time. A feedback-enable input turns the reload path off, and the chain then runs as a plain modulus-2^WIDTH counter. An active-low synchronous clear has priority over every other input.

Top module: `trc_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` is 0 after that edge, whatever `preset_req` and the carry are doing.
- R2: With `clr_n` high and no load pending, `count` increases by exactly one at each rising edge.
- R3: `carry` is 1 exactly when every bit of `count` is 1. It is a combinational output.
- R4: With `reload_en` = 1, the rising edge at which `carry` is 1 loads PRESET, so 4'hF is followed by 4'h9 and 12'hFFF is followed by 12'h800.
- R5: `preset_req` = 1 at a rising edge (with `clr_n` high) loads PRESET on that edge, from any count.
- R6: With `reload_en` = 1, the count returns to PRESET every 2^WIDTH − PRESET edges: 7 edges for the 4-bit build and 2048 edges for the 12-bit build.
- R7: With `reload_en` = 0, all ones is followed by 0, and the period is 2^WIDTH (4096 for 12 bits).
- R8: After a clear, the counter climbs 0, 1, 2, … up to all ones before it enters the truncated loop, and state 0 never appears inside the loop.
- R9: A 4-bit stage advances only when every stage below it shows all ones, so 12'h0FF is followed by 12'h100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| preset_req | input | 1 | Forces PRESET into the count on the next edge |
| reload_en | input | 1 | 1: the carry reloads PRESET; 0: the count wraps to zero |
| count | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count indication, high when the count is all ones |

## Verification
The bench climbs from a clear through all ones to show the first pass includes state 0 and that the loop after it never does. A design that reloaded on a decoded end state, or that forgot the carry feedback, would wrap to 0 or leave the loop one state early.

It asserts the start request and the clear together to catch a priority inversion, which would leave the preset in place of zero. It crosses 12'h0FF to catch a carry chain that lets an upper stage move too early or too late.

It measures whole loop lengths with the feedback on and off, so an off-by-one modulus shows up as 2047, 2049, or 4095.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int STAGE_W = 4;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } stage_op_e;

    typedef struct packed {
        logic clear;
        logic load;
    } stage_ctl_t;

    // Priority: clear, then load, then count when enabled.
    function automatic stage_op_e pick_op(stage_ctl_t ctl, logic ent);
        if (ctl.clear)     return OP_CLEAR;
        else if (ctl.load) return OP_LOAD;
        else if (ent)      return OP_COUNT;
        else               return OP_HOLD;
    endfunction

endpackage

// File: rtl/trc_load_ctl.sv
module trc_load_ctl
    import trc_pkg::*;
(
    input  logic       clr_n,
    input  logic       preset_req,
    input  logic       reload_en,
    input  logic       carry,
    output stage_ctl_t ctl
);

    always_comb begin
        ctl.clear = ~clr_n;
        // Effective load: the external request OR the terminal-count feedback.
        ctl.load  = preset_req | (reload_en & carry);
    end

endmodule

// File: rtl/trc_stage.sv
module trc_stage
    import trc_pkg::*;
#(
    parameter int W = STAGE_W
) (
    input  logic         clk,
    input  stage_ctl_t   ctl,
    input  logic         ent,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rco
);

    stage_op_e op;

    always_comb op = pick_op(ctl, ent);

    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= din;
            OP_COUNT: q <= q + W'(1);
            default:  q <= q;
        endcase
    end

    assign rco = ent & (&q);

    // A stage whose enable is low and that is not loading keeps its value.
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (ctl.clear)
        (!ent && !ctl.load) |=> $stable(q)) else $error("stage moved without enable"); // R9

endmodule

// File: rtl/trc_counter.sv
module trc_counter
    import trc_pkg::*;
#(
    parameter int               WIDTH  = 12,
    parameter logic [WIDTH-1:0] PRESET = 12'h800
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             preset_req,
    input  logic             reload_en,
    output logic [WIDTH-1:0] count,
    output logic             carry
);

    localparam int NSTG = (WIDTH + STAGE_W - 1) / STAGE_W;

    stage_ctl_t        ctl;
    logic [NSTG:0]     ent_chain;

    assign ent_chain[0] = 1'b1;
    assign carry        = ent_chain[NSTG];

    trc_load_ctl u_ctl (
        .clr_n      (clr_n),
        .preset_req (preset_req),
        .reload_en  (reload_en),
        .carry      (carry),
        .ctl        (ctl)
    );

    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        localparam int LO = i * STAGE_W;
        localparam int SW = (i == NSTG - 1) ? (WIDTH - LO) : STAGE_W;
        trc_stage #(.W(SW)) u_stage (
            .clk (clk),
            .ctl (ctl),
            .ent (ent_chain[i]),
            .din (PRESET[LO +: SW]),
            .q   (count[LO +: SW]),
            .rco (ent_chain[i+1])
        );
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !clr_n |=> count == '0) else $error("clear did not zero"); // R1
    AST_CARRY_ONES: assert property (@(posedge clk) disable iff (!clr_n)
        carry == (&count)) else $error("carry mismatch"); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clr_n)
        (!preset_req && !(reload_en && carry)) |=> count == $past(count) + WIDTH'(1))
        else $error("bad increment"); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!clr_n)
        (reload_en && carry) |=> count == PRESET) else $error("no reload"); // R4
    AST_FORCE: assert property (@(posedge clk) disable iff (!clr_n)
        preset_req |=> count == PRESET) else $error("no forced load"); // R5
    AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (!reload_en && !preset_req && carry) |=> count == '0) else $error("no wrap"); // R7

endmodule

// File: tb/trc_counter_tb.sv
`timescale 1ns/1ps
module trc_counter_tb_top;

    localparam int W12 = 12;
    localparam int W4  = 4;
    localparam logic [W12-1:0] P12 = 12'h800;
    localparam logic [W4-1:0]  P4  = 4'h9;

    logic clk = 1'b0;
    logic clr_n, preset_req, reload_en;
    logic [W12-1:0] count12;
    logic [W4-1:0]  count4;
    logic carry12, carry4;

    int checks = 0;
    int errors = 0;
    logic [W12-1:0] m12;
    logic [W4-1:0]  m4;

    always #2 clk = ~clk;

    trc_counter #(.WIDTH(W12), .PRESET(P12)) dut_i (
        .clk(clk), .clr_n(clr_n), .preset_req(preset_req), .reload_en(reload_en),
        .count(count12), .carry(carry12));

    trc_counter #(.WIDTH(W4), .PRESET(P4)) dut4_i (
        .clk(clk), .clr_n(clr_n), .preset_req(preset_req), .reload_en(reload_en),
        .count(count4), .carry(carry4));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Next state taken from the requirements: clear, then load, then +1.
    function automatic logic [W12-1:0] nxt12(logic [W12-1:0] v);
        if (!clr_n) return '0;
        if (preset_req || (reload_en && v == '1)) return P12;
        return v + 1'b1;
    endfunction

    function automatic logic [W4-1:0] nxt4(logic [W4-1:0] v);
        if (!clr_n) return '0;
        if (preset_req || (reload_en && v == '1)) return P4;
        return v + 1'b1;
    endfunction

    // One edge with model comparison of counts and carries.
    task automatic step(input string tag);
        m12 = nxt12(m12);
        m4  = nxt4(m4);
        @(posedge clk); #1;
        chk(count12 == m12, {tag, " count12"}, count12, m12);
        chk(count4 == m4, {tag, " count4"}, count4, m4);
        chk(carry12 == (m12 == '1), "R3 carry12", carry12, (m12 == '1));
        chk(carry4 == (m4 == '1), "R3 carry4", carry4, (m4 == '1));
    endtask

    task automatic t_reset();
        clr_n = 1'b0; preset_req = 1'b0; reload_en = 1'b1;
        m12 = '0; m4 = '0;
        step("R1 reset");
        step("R1 reset");
    endtask

    task automatic t_clear_priority();
        clr_n = 1'b1;
        step("R2 pre");
        step("R2 pre");
        clr_n = 1'b0; preset_req = 1'b1;
        step("R1 clear over load");
        chk(count12 == 0, "R1 clear wins", count12, 0);
        preset_req = 1'b0;
        step("R1 hold clear");
    endtask

    task automatic t_climb();
        clr_n = 1'b1; reload_en = 1'b1;
        for (int k = 1; k <= 15; k++) step("R8 climb");
        chk(count4 == 4'hF, "R8 reaches all ones", count4, 4'hF);
        step("R4 reload4");
        chk(count4 == P4, "R4 4-bit reload", count4, P4);
        while (m12 != 12'h0FF) step("R2 run");
        step("R9 chain");
        chk(count12 == 12'h100, "R9 upper stage advance", count12, 12'h100);
        while (m12 != 12'hFFF) step("R8 climb12");
        chk(carry12 == 1'b1, "R3 terminal carry", carry12, 1);
        step("R4 reload12");
        chk(count12 == P12, "R4 12-bit reload", count12, P12);
    endtask

    task automatic t_period();
        int n = 0;
        do begin step("R6 loop12"); n++; end while (count12 != P12 && n < 5000);
        chk(n == 2048, "R6 modulus 2048", n, 2048);
        while (count4 != P4) step("R6 align4");
        n = 0;
        do begin step("R6 loop4"); n++; chk(count4 != 0, "R8 no zero in loop", count4, 1); end
            while (count4 != P4 && n < 50);
        chk(n == 7, "R6 modulus 7", n, 7);
    endtask

    task automatic t_force();
        step("R2 pre");
        step("R2 pre");
        preset_req = 1'b1;
        step("R5 force");
        chk(count12 == P12, "R5 forced preset12", count12, P12);
        chk(count4 == P4, "R5 forced preset4", count4, P4);
        preset_req = 1'b0;
        step("R2 after force");
    endtask

    task automatic t_noreload();
        int n = 0;
        clr_n = 1'b0;
        step("R1 clear");
        clr_n = 1'b1; reload_en = 1'b0;
        while (m4 != 4'hF) step("R7 run4");
        step("R7 wrap4");
        chk(count4 == 0, "R7 4-bit wrap", count4, 0);
        do begin step("R7 run12"); n++; end while (count12 != 0 && n < 5000);
        chk(n == 4096 - 16, "R7 wrap12", n, 4096 - 16);
        n = 0;
        do begin step("R7 full12"); n++; end while (count12 != 0 && n < 5000);
        chk(n == 4096, "R7 modulus 4096", n, 4096);
    endtask

    initial begin
        t_reset();
        t_clear_priority();
        t_climb();
        t_period();
        t_force();
        t_noreload();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule